// File: doc/BRIEF.md
# Indexed Address Translation Window Unit

This block holds a set of address translation windows for a bridge between a local bus and a peripheral interconnect. There are `NUM_WIN` windows for traffic leaving the host (outbound) and `NUM_WIN` windows for traffic arriving at it (inbound). Software reaches every window through a single index register. That register selects a direction and a window number. All later window register accesses act on the window it selects.

Each window keeps a 64-bit base, a 32-bit upper bound, a 64-bit target and two control words. Writes to the window fields go into stored copies only. The lookup logic sees them only when the second control word is written. That write also carries the enable bit.

A combinational lookup port takes an address and a direction. It reports whether a window claims the address. For a memory window it gives the translated address. For an outbound window whose type word is nonzero, it gives the bus number, device/function and register offset of a configuration access instead.

Top module: `atu_xlate_unit`

## Requirements
- R1: After reset, the index register reads 0. Every window reads base 0, target 0, upper bound 0xFFFFFFFF, type word 0 and control word 0, except inbound window 0, whose control word reads 0x80000000.
- R2: A write to the index register (offset 0x900) stores the written value ANDed with (0x80000000 | (NUM_WIN-1)). Bit 31 = 1 selects the inbound set. The low bits select the window number.
- R3: Window registers act on the selected window and read back its stored values. The offsets are: 0x904 type word, 0x908 control word, 0x90C/0x910 base low/high, 0x914 upper bound, 0x918/0x91C target low/high. Any other offset reads 0.
- R4: Writes to the base, upper bound, target or type word leave the lookup result unchanged until the control word of that window is written.
- R5: A control word write applies the window's stored fields. Its bit 31 enables the window; a disabled window never hits.
- R6: A window hits an address A when (A - base) mod 2^64 <= (zero-extended bound - base) mod 2^64. With base <= bound, this is the inclusive range base..bound.
- R7: For a memory window, the translated address is A - base + target. The lookup reports type 0.
- R8: An outbound window whose applied type word is nonzero is a configuration window. For such a window the lookup reports type 1, bus = target[31:24], device/function = target[23:16], register offset = (A - base)[11:0] and translated address 0. Memory hits report bus, device/function and offset as 0. Inbound windows always act as memory windows.
- R9: Only the windows of the requested direction take part. When several hit, the lowest window number wins.
- R10: With no hit, all lookup outputs are 0.
- R11: Straight after reset, inbound addresses 0..0xFFFFFFFF pass through unchanged, and every outbound lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| lk_addr | input | 64 | Address to translate |
| lk_inbound | input | 1 | Lookup direction, 1 = inbound |
| lk_hit | output | 1 | A window claims lk_addr |
| lk_cfg | output | 1 | Hit is a configuration window |
| lk_xlat | output | 64 | Translated address (memory hits) |
| lk_bus | output | 8 | Bus number (configuration hits) |
| lk_devfn | output | 8 | Device/function (configuration hits) |
| lk_reg_off | output | 12 | Register offset (configuration hits) |

## Verification
The assertions check the following on every cycle:
- the miss outputs are quiet;
- the configuration fields appear only on outbound configuration hits;
- the index register never shows bits outside its mask;
- the lookup result holds steady when neither its inputs nor a control word write changed.

The bench's scenarios are needed for the rest:
- the translated values and range edges;
- the lowest-number priority among overlapping windows;
- the reset window and the fact that inbound windows ignore the type word.

A reference model driven by random programming covers these.

// File: rtl/atu_pkg.sv
`timescale 1ns/1ps
package atu_pkg;
  localparam logic [11:0] OFS_VIEW    = 12'h900;
  localparam logic [11:0] OFS_TYPE    = 12'h904;
  localparam logic [11:0] OFS_CTL     = 12'h908;
  localparam logic [11:0] OFS_BASE_LO = 12'h90C;
  localparam logic [11:0] OFS_BASE_HI = 12'h910;
  localparam logic [11:0] OFS_BOUND   = 12'h914;
  localparam logic [11:0] OFS_TGT_LO  = 12'h918;
  localparam logic [11:0] OFS_TGT_HI  = 12'h91C;

  // values as software stored them
  typedef struct packed {
    logic [63:0] base;
    logic [31:0] bound;
    logic [63:0] target;
    logic [31:0] kind;
    logic [31:0] ctl;
  } win_regs_t;

  // values the lookup uses, captured on a control word write
  typedef struct packed {
    logic        en;
    logic        cfg;
    logic [63:0] base;
    logic [63:0] span;
    logic [63:0] target;
  } win_live_t;
endpackage

// File: rtl/atu_regfile.sv
`timescale 1ns/1ps
module atu_regfile
  import atu_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [11:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output win_live_t   live_o [2*NW]
);
  localparam int IW = $clog2(NW);
  localparam int SN = 2 * NW;
  localparam logic [31:0] VP_MASK = 32'h8000_0000 | 32'(NW - 1);

  logic [31:0] vp_q, vp_d;
  win_regs_t   regs_q [SN];
  win_regs_t   regs_d [SN];
  win_live_t   live_q [SN];
  win_live_t   live_d [SN];
  logic [IW:0] sel;

  assign sel = {vp_q[31], vp_q[IW-1:0]};

  always_comb begin
    vp_d   = vp_q;
    regs_d = regs_q;
    live_d = live_q;
    if (wr_i) begin
      case (addr_i)
        OFS_VIEW:    vp_d = wdata_i & VP_MASK;
        OFS_TYPE:    regs_d[sel].kind = wdata_i;
        OFS_BASE_LO: regs_d[sel].base[31:0] = wdata_i;
        OFS_BASE_HI: regs_d[sel].base[63:32] = wdata_i;
        OFS_BOUND:   regs_d[sel].bound = wdata_i;
        OFS_TGT_LO:  regs_d[sel].target[31:0] = wdata_i;
        OFS_TGT_HI:  regs_d[sel].target[63:32] = wdata_i;
        OFS_CTL: begin
          regs_d[sel].ctl    = wdata_i;
          live_d[sel].en     = wdata_i[31];
          live_d[sel].cfg    = (regs_q[sel].kind != 32'd0) && !sel[IW];
          live_d[sel].base   = regs_q[sel].base;
          live_d[sel].span   = {32'd0, regs_q[sel].bound} - regs_q[sel].base;
          live_d[sel].target = regs_q[sel].target;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp_q <= '0;
      for (int s = 0; s < SN; s++) begin
        regs_q[s] <= '{base: '0, bound: '1, target: '0, kind: '0,
                       ctl: (s == NW) ? 32'h8000_0000 : 32'd0};
        live_q[s] <= '{en: (s == NW), cfg: 1'b0, base: '0,
                       span: 64'h0000_0000_FFFF_FFFF, target: '0};
      end
    end else begin
      vp_q   <= vp_d;
      regs_q <= regs_d;
      live_q <= live_d;
    end
  end

  always_comb begin
    case (addr_i)
      OFS_VIEW:    rdata_o = vp_q;
      OFS_TYPE:    rdata_o = regs_q[sel].kind;
      OFS_CTL:     rdata_o = regs_q[sel].ctl;
      OFS_BASE_LO: rdata_o = regs_q[sel].base[31:0];
      OFS_BASE_HI: rdata_o = regs_q[sel].base[63:32];
      OFS_BOUND:   rdata_o = regs_q[sel].bound;
      OFS_TGT_LO:  rdata_o = regs_q[sel].target[31:0];
      OFS_TGT_HI:  rdata_o = regs_q[sel].target[63:32];
      default:     rdata_o = 32'd0;
    endcase
  end

  assign live_o = live_q;
endmodule

// File: rtl/atu_win_match.sv
`timescale 1ns/1ps
module atu_win_match
  import atu_pkg::*;
(
  input  win_live_t   win_i,
  input  logic [63:0] addr_i,
  output logic        hit_o,
  output logic [63:0] off_o
);
  assign off_o = addr_i - win_i.base;
  assign hit_o = win_i.en && (off_o <= win_i.span);
endmodule

// File: rtl/atu_pick.sv
`timescale 1ns/1ps
module atu_pick #(
  parameter int NW = 4,
  localparam int IW = $clog2(NW)
) (
  input  logic [NW-1:0] hit_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (hit_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/atu_xlate_unit.sv
`timescale 1ns/1ps
module atu_xlate_unit
  import atu_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [63:0] lk_addr,
  input  logic        lk_inbound,
  output logic        lk_hit,
  output logic        lk_cfg,
  output logic [63:0] lk_xlat,
  output logic [7:0]  lk_bus,
  output logic [7:0]  lk_devfn,
  output logic [11:0] lk_reg_off
);
  localparam int IW = $clog2(NUM_WIN);
  localparam int SN = 2 * NUM_WIN;

  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  win_live_t live [SN];

  atu_regfile #(.NW(NUM_WIN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .rdata_o (reg_rdata),
    .live_o  (live)
  );

  win_live_t          dir_win [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic [63:0]        off [NUM_WIN];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign dir_win[i] = lk_inbound ? live[NUM_WIN + i] : live[i];
    atu_win_match u_match (
      .win_i  (dir_win[i]),
      .addr_i (lk_addr),
      .hit_o  (hit[i]),
      .off_o  (off[i])
    );
  end

  logic          any;
  logic [IW-1:0] pick;

  atu_pick #(.NW(NUM_WIN)) u_pick (
    .hit_i (hit),
    .any_o (any),
    .idx_o (pick)
  );

  always_comb begin
    lk_hit     = any;
    lk_cfg     = 1'b0;
    lk_xlat    = '0;
    lk_bus     = '0;
    lk_devfn   = '0;
    lk_reg_off = '0;
    if (any) begin
      if (dir_win[pick].cfg) begin
        lk_cfg     = 1'b1;
        lk_bus     = dir_win[pick].target[31:24];
        lk_devfn   = dir_win[pick].target[23:16];
        lk_reg_off = off[pick][11:0];
      end else begin
        lk_xlat = off[pick] + dir_win[pick].target;
      end
    end
  end
endmodule

// File: rtl/atu_xlate_checker.sv
`timescale 1ns/1ps
module atu_xlate_checker #(
  parameter int NUM_WIN = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic [63:0] lk_addr,
  input logic        lk_inbound,
  input logic        lk_hit,
  input logic        lk_cfg,
  input logic [63:0] lk_xlat,
  input logic [7:0]  lk_bus,
  input logic [7:0]  lk_devfn,
  input logic [11:0] lk_reg_off
);
  localparam logic [31:0] VP_MASK = 32'h8000_0000 | 32'(NUM_WIN - 1);

  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_xlat == 64'd0 && !lk_cfg && lk_bus == 8'd0 &&
                 lk_devfn == 8'd0 && lk_reg_off == 12'd0));

  p_view_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 12'h900) |-> ((reg_rdata & ~VP_MASK) == 32'd0));

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr && reg_addr == 12'h908) && $stable(lk_addr) && $stable(lk_inbound))
      |-> ($stable(lk_hit) && $stable(lk_xlat) && $stable(lk_cfg)));

  p_cfg_outbound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cfg |-> (lk_hit && !lk_inbound && lk_xlat == 64'd0));

  p_mem_fields_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !lk_cfg) |-> (lk_bus == 8'd0 && lk_devfn == 8'd0 && lk_reg_off == 12'd0));
endmodule

bind atu_xlate_unit atu_xlate_checker #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .lk_addr    (lk_addr),
  .lk_inbound (lk_inbound),
  .lk_hit     (lk_hit),
  .lk_cfg     (lk_cfg),
  .lk_xlat    (lk_xlat),
  .lk_bus     (lk_bus),
  .lk_devfn   (lk_devfn),
  .lk_reg_off (lk_reg_off)
);

// File: tb/sim_atu_xlate_unit.sv
`timescale 1ns/1ps
module sim_atu_xlate_unit;
  localparam int NW = 4;
  localparam int SN = 2 * NW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [63:0] lk_addr;
  logic        lk_inbound;
  logic        lk_hit, lk_cfg;
  logic [63:0] lk_xlat;
  logic [7:0]  lk_bus, lk_devfn;
  logic [11:0] lk_reg_off;

  always #2.5 clk = ~clk;

  atu_xlate_unit #(.NUM_WIN(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_inbound(lk_inbound), .lk_hit(lk_hit), .lk_cfg(lk_cfg),
    .lk_xlat(lk_xlat), .lk_bus(lk_bus), .lk_devfn(lk_devfn),
    .lk_reg_off(lk_reg_off)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model of the requirements
  logic [31:0] m_vp;
  logic [63:0] s_base [SN];
  logic [31:0] s_bound [SN];
  logic [63:0] s_tgt [SN];
  logic [31:0] s_kind [SN];
  logic [31:0] s_ctl [SN];
  logic        a_en [SN];
  logic        a_cfg [SN];
  logic [63:0] a_base [SN];
  logic [63:0] a_bound [SN];
  logic [63:0] a_tgt [SN];

  function automatic int msel();
    return (m_vp[31] ? NW : 0) + int'(m_vp & 32'(NW - 1));
  endfunction

  task automatic model_reset();
    m_vp = '0;
    for (int s = 0; s < SN; s++) begin
      s_base[s] = '0; s_bound[s] = 32'hFFFF_FFFF; s_tgt[s] = '0; s_kind[s] = '0;
      s_ctl[s] = (s == NW) ? 32'h8000_0000 : 32'd0;
      a_en[s] = (s == NW); a_cfg[s] = 1'b0; a_base[s] = '0;
      a_bound[s] = 64'hFFFF_FFFF; a_tgt[s] = '0;
    end
  endtask

  task automatic model_write(input logic [11:0] ofs, input logic [31:0] d);
    int s;
    s = msel();
    case (ofs)
      12'h900: m_vp = d & (32'h8000_0000 | 32'(NW - 1));
      12'h904: s_kind[s] = d;
      12'h90C: s_base[s][31:0] = d;
      12'h910: s_base[s][63:32] = d;
      12'h914: s_bound[s] = d;
      12'h918: s_tgt[s][31:0] = d;
      12'h91C: s_tgt[s][63:32] = d;
      12'h908: begin
        s_ctl[s] = d; a_en[s] = d[31]; a_cfg[s] = (s_kind[s] != 0) && (s < NW);
        a_base[s] = s_base[s]; a_bound[s] = {32'd0, s_bound[s]}; a_tgt[s] = s_tgt[s];
      end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] ofs);
    int s;
    s = msel();
    case (ofs)
      12'h900: return m_vp;
      12'h904: return s_kind[s];
      12'h908: return s_ctl[s];
      12'h90C: return s_base[s][31:0];
      12'h910: return s_base[s][63:32];
      12'h914: return s_bound[s];
      12'h918: return s_tgt[s][31:0];
      12'h91C: return s_tgt[s][63:32];
      default: return 32'd0;
    endcase
  endfunction

  // packed {hit, cfg, xlat, bus, devfn, off}
  function automatic logic [127:0] model_lookup(input logic [63:0] a, input logic inb);
    logic [63:0] off;
    for (int i = 0; i < NW; i++) begin
      int s;
      s = inb ? NW + i : i;
      off = a - a_base[s];
      if (a_en[s] && off <= (a_bound[s] - a_base[s])) begin
        if (a_cfg[s])
          return {34'd0, 1'b1, 1'b1, 64'd0, a_tgt[s][31:24], a_tgt[s][23:16], off[11:0]};
        else
          return {34'd0, 1'b1, 1'b0, off + a_tgt[s], 8'd0, 8'd0, 12'd0};
      end
    end
    return '0;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ofs; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    model_write(ofs, d);
  endtask

  task automatic rchk(input logic [11:0] ofs, input string tag);
    @(negedge clk);
    reg_addr = ofs;
    #1;
    check(tag, {96'd0, reg_rdata}, {96'd0, model_read(ofs)});
  endtask

  task automatic lchk(input logic [63:0] a, input logic inb, input string tag);
    @(negedge clk);
    lk_addr = a; lk_inbound = inb;
    #1;
    check(tag, {34'd0, lk_hit, lk_cfg, lk_xlat, lk_bus, lk_devfn, lk_reg_off},
          model_lookup(a, inb));
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] ofs_tab [8];
    ofs_tab = '{12'h900, 12'h904, 12'h908, 12'h90C, 12'h910, 12'h914, 12'h918, 12'h91C};
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    lk_addr = '0; lk_inbound = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rchk(12'h900, "R1 index");
    check("R1 index literal", {96'd0, reg_rdata}, 128'd0);
    wreg(12'h900, 32'h8000_0000);
    rchk(12'h908, "R1 inbound0 ctl");
    check("R1 inbound0 ctl literal", {96'd0, reg_rdata}, {96'd0, 32'h8000_0000});
    rchk(12'h914, "R1 bound");
    wreg(12'h900, 32'h0000_0003);
    rchk(12'h908, "R1 outbound3 ctl");
    rchk(12'h90C, "R1 base");

    // R11 reset window
    lchk(64'h1234_5678, 1'b1, "R11 inbound identity");
    check("R11 literal", {64'd0, lk_xlat}, {64'd0, 64'h1234_5678});
    lchk(64'hFFFF_FFFF, 1'b1, "R11 inbound top");
    lchk(64'h1_0000_0000, 1'b1, "R11 beyond 4G");
    lchk(64'h100, 1'b0, "R10 outbound miss");

    // R2 masking
    wreg(12'h900, 32'hFFFF_FFF6);
    rchk(12'h900, "R2 mask");
    check("R2 literal", {96'd0, reg_rdata}, {96'd0, 32'h8000_0002});

    // R3 R4 program outbound 1
    wreg(12'h900, 32'h1);
    wreg(12'h90C, 32'h2000); wreg(12'h910, 32'h0);
    wreg(12'h914, 32'h2FFF);
    wreg(12'h918, 32'h5000_0000); wreg(12'h91C, 32'h1);
    for (int k = 1; k < 8; k++) rchk(ofs_tab[k], "R3 readback");
    rchk(12'h7F0, "R3 unmapped reads 0");
    lchk(64'h2100, 1'b0, "R4 not yet applied");
    check("R4 literal", {127'd0, lk_hit}, 128'd0);

    // R5 R7 R6
    wreg(12'h908, 32'h8000_0000);
    lchk(64'h2100, 1'b0, "R7 translate");
    check("R7 literal", {64'd0, lk_xlat}, {64'd0, 64'h1_5000_0100});
    lchk(64'h2000, 1'b0, "R6 low edge");
    lchk(64'h2FFF, 1'b0, "R6 high edge");
    lchk(64'h3000, 1'b0, "R6 above");
    lchk(64'h1FFF, 1'b0, "R6 below");

    // R9 priority
    wreg(12'h900, 32'h2);
    wreg(12'h90C, 32'h2800); wreg(12'h914, 32'h3FFF); wreg(12'h918, 32'h0);
    wreg(12'h908, 32'h8000_0000);
    lchk(64'h2900, 1'b0, "R9 lowest wins");
    check("R9 literal", {64'd0, lk_xlat}, {64'd0, 64'h1_5000_0900});
    lchk(64'h3100, 1'b0, "R9 second window");

    // R8 configuration window
    wreg(12'h900, 32'h3);
    wreg(12'h90C, 32'h8000); wreg(12'h914, 32'h8FFF); wreg(12'h918, 32'h1234_0000);
    wreg(12'h904, 32'h4);
    wreg(12'h908, 32'h8000_0000);
    lchk(64'h8ABC, 1'b0, "R8 cfg fields");
    check("R8 literal", {88'd0, lk_cfg, lk_bus, lk_devfn, lk_reg_off},
          {88'd0, 1'b1, 8'h12, 8'h34, 12'hABC});

    // R8 inbound ignores type word; R9 inbound 0 first; R5 disable
    wreg(12'h900, 32'h8000_0001);
    wreg(12'h90C, 32'h8000); wreg(12'h914, 32'h8FFF); wreg(12'h918, 32'h100);
    wreg(12'h904, 32'h4);
    wreg(12'h908, 32'h8000_0000);
    lchk(64'h8ABC, 1'b1, "R9 inbound0 wins");
    wreg(12'h900, 32'h8000_0000);
    wreg(12'h908, 32'h0);
    lchk(64'h8ABC, 1'b1, "R8 inbound memory");
    check("R8 inbound literal", {63'd0, lk_cfg, lk_xlat}, {64'd0, 64'hBBC});
    wreg(12'h900, 32'h1);
    wreg(12'h908, 32'h0);
    lchk(64'h2100, 1'b0, "R5 disabled");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 9));
      case (op)
        0: wreg(12'h900, $urandom());
        1: wreg(12'h90C, $urandom_range(0, 32'h1FFFF));
        2: wreg(12'h914, $urandom_range(0, 32'h2FFFF));
        3: wreg(12'h918, $urandom());
        4: wreg(12'h91C, $urandom_range(0, 3));
        5: begin d = ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom(); wreg(12'h904, d); end
        6: wreg(12'h908, {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, 31'd0});
        7: rchk(ofs_tab[$urandom_range(0, 7)], "R3 random readback");
        default: ;
      endcase
      lchk({32'd0, 32'($urandom_range(0, 32'h2FFFF))}, $urandom_range(0, 1) == 1,
           "R7/R9 random lookup");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule